// File: doc/BRIEF.md
# Programmable Parallel Port with Handshake

This block is a bus-attached parallel I/O peripheral with three 8-bit ports, A, B and C. A host writes a control byte that configures the ports. It then moves data through a small register interface with chip select, two address bits, read and write strobes and 8-bit data buses.

Ports A and B each run as a plain 8-bit input or output. Port C splits into two 4-bit halves, and each half has its own direction. Port B can also run in a strobed mode with a handshake. Port A can run in a strobed mode or in a bidirectional mode. The handshake lines for port A are taken from the upper half of port C, and those for port B from the lower half.

Every pin is split into an input, an output value and an output enable, so the pad ring can build the tristate buffers. All outputs come from flops, or from a multiplexer between flops. Reads return data one clock after the read strobe.

Top module: `parallel_io_port`

## Requirements
- R1: After synchronous reset, reading the control address returns 9Bh (all ports are inputs, simple mode), `pa_oe`, `pb_oe` and `pc_oe` are all zero, and every handshake flag is clear.
- R2: A write to address 3 with bit 7 set loads the configuration, and a read of address 3 returns it. The fields are: bits 6:5 port A mode (00 simple, 01 strobed, 1x bidirectional), bit 4 port A is input, bit 3 upper C is input, bit 2 port B strobed, bit 1 port B is input, bit 0 lower C is input. The same write clears the output latches of A, B and C and all handshake flags.
- R3: A write to address 3 with bit 7 clear changes nothing: the configuration readback and all port outputs keep their values.
- R4: In simple mode, an output port drives the last byte written to it (address 0 for A, address 1 for B), with its enable high. A read of an input port returns the level on its pins at the read edge.
- R5: The two halves of port C take their directions independently. A read of address 2 returns the latch value on driven bits and the pin level on all other bits.
- R6: In strobed input mode, a high-to-low transition on the strobe line captures the port pins and sets the input-full flag. A later read of the port returns the captured byte, not the current pins, and clears the flag unless a new strobe arrives in the same cycle.
- R7: In strobed output mode, a write to the port sets the data-ready flag and the port drives the written byte. A high-to-low transition on the acknowledge line clears the flag. A write in the same cycle as the acknowledge wins.
- R8: Handshake pin map. For port A: C4 is the input strobe (in), C5 is input-full (out), C6 is the output acknowledge (in), C7 is data-ready (out). For port B in strobed mode: C0 is the strobe or acknowledge (in), C1 is full or data-ready (out). Handshake outputs are always driven. The remaining C bits follow their half's direction.
- R9: In bidirectional mode, port A uses both the input handshake and the output handshake. `pa_oe` is high only in the cycle after C6 is sampled low.
- R10: `rdata` updates on the clock edge that samples `cs` and `rd` high, and holds otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| addr | input | 2 | Register address: 0 A, 1 B, 2 C, 3 control |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output value |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output value |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output values |
| pc_oe | output | 8 | Port C per-bit output enables |

## Verification
The assertions assume that `rd` and `wr` are never high together while `cs` is asserted. They also assume that the port C strobe and acknowledge lines are already synchronous to `clk`, so each transition is seen exactly once by the edge detectors. The bench drives every input on the falling clock edge. Its bus tasks assert only one strobe at a time, and each handshake pulse is held low for one full cycle before it is released high.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int DW = 8;
  localparam int HW = DW / 2;

  localparam logic [1:0] AM_SIMPLE = 2'b00;
  localparam logic [1:0] AM_STROBE = 2'b01;

  typedef struct packed {
    logic       define;
    logic [1:0] a_mode;
    logic       a_in;
    logic       cu_in;
    logic       b_stb;
    logic       b_in;
    logic       cl_in;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{define: 1'b1, a_mode: AM_SIMPLE, a_in: 1'b1,
                                 cu_in: 1'b1, b_stb: 1'b0, b_in: 1'b1, cl_in: 1'b1};

  localparam logic [1:0] ADR_A = 2'd0;
  localparam logic [1:0] ADR_B = 2'd1;
  localparam logic [1:0] ADR_C = 2'd2;
  localparam logic [1:0] ADR_K = 2'd3;
endpackage

// File: rtl/pp_busif.sv
module pp_busif #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic [1:0]    addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] b_val,
  input  logic [DW-1:0] c_val,
  input  logic [DW-1:0] k_val,
  output logic          we_a,
  output logic          we_b,
  output logic          we_c,
  output logic          we_k,
  output logic          re_a,
  output logic          re_b,
  output logic [DW-1:0] rdata
);
  import pp_pkg::*;

  logic acc_wr, acc_rd;
  logic [DW-1:0] sel_val;

  assign acc_wr = cs && wr;
  assign acc_rd = cs && rd;
  assign we_a   = acc_wr && (addr == ADR_A);
  assign we_b   = acc_wr && (addr == ADR_B);
  assign we_c   = acc_wr && (addr == ADR_C);
  assign we_k   = acc_wr && (addr == ADR_K) && wdata[DW-1];
  assign re_a   = acc_rd && (addr == ADR_A);
  assign re_b   = acc_rd && (addr == ADR_B);

  always_comb begin
    unique case (addr)
      ADR_A:   sel_val = a_val;
      ADR_B:   sel_val = b_val;
      ADR_C:   sel_val = c_val;
      default: sel_val = k_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata <= '0;
    else if (acc_rd) rdata <= sel_val;
  end

  // R10: one bus strobe per access, and rdata holds when no read is sampled
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(cs && rd && wr));
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> $stable(rdata));
endmodule

// File: rtl/pp_hs.sv
module pp_hs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          in_en,
  input  logic          out_en,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] wdata,
  input  logic          strobe_n,
  input  logic          take_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] in_q,
  output logic          full,
  output logic          avail
);
  logic prev_s, prev_t;
  logic fall_s, fall_t;

  assign fall_s = prev_s && !strobe_n;
  assign fall_t = prev_t && !take_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_s <= 1'b1;
      prev_t <= 1'b1;
      out_q  <= '0;
      in_q   <= '0;
      full   <= 1'b0;
      avail  <= 1'b0;
    end else begin
      prev_s <= strobe_n;
      prev_t <= take_n;
      if (clr) begin
        out_q <= '0;
        in_q  <= '0;
        full  <= 1'b0;
        avail <= 1'b0;
      end else begin
        if (cpu_wr) out_q <= wdata;
        if (in_en && fall_s) begin
          in_q <= din;
          full <= 1'b1;
        end else if (cpu_rd) begin
          full <= 1'b0;
        end
        if (out_en && cpu_wr) avail <= 1'b1;
        else if (fall_t)      avail <= 1'b0;
      end
    end
  end

  // R6: strobe edge captures data and raises the full flag; read clears it
  a_r6_capture: assert property (@(posedge clk) disable iff (rst)
    (!clr && in_en && fall_s) |=> (full && in_q == $past(din)));
  a_r6_read_clear: assert property (@(posedge clk) disable iff (rst)
    (!clr && cpu_rd && !(in_en && fall_s)) |=> !full);
  // R7: a port write raises data-ready; acknowledge edge drops it
  a_r7_avail_set: assert property (@(posedge clk) disable iff (rst)
    (!clr && out_en && cpu_wr) |=> (avail && out_q == $past(wdata)));
  a_r7_take_clear: assert property (@(posedge clk) disable iff (rst)
    (!clr && fall_t && !cpu_wr) |=> !avail);
endmodule

// File: rtl/pp_portc.sv
module pp_portc #(
  parameter int DW = 8
) (
  input  pp_pkg::cfg_t  cfg,
  input  logic [DW-1:0] c_lat,
  input  logic [DW-1:0] pc_in,
  input  logic          a_full,
  input  logic          a_avail,
  input  logic          b_flag,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe,
  output logic [DW-1:0] c_val
);
  import pp_pkg::*;

  logic a_sin, a_sout, a_bid;
  logic [DW-1:0] hs_in, hs_out, hs_val, gen_dir;

  assign a_bid  = cfg.a_mode[1];
  assign a_sin  = (cfg.a_mode == AM_STROBE) && cfg.a_in;
  assign a_sout = (cfg.a_mode == AM_STROBE) && !cfg.a_in;

  always_comb begin
    hs_in  = '0;
    hs_out = '0;
    hs_val = '0;
    hs_in[HW]    = a_sin || a_bid;
    hs_out[HW+1] = a_sin || a_bid;
    hs_in[HW+2]  = a_sout || a_bid;
    hs_out[HW+3] = a_sout || a_bid;
    hs_in[0]     = cfg.b_stb;
    hs_out[1]    = cfg.b_stb;
    hs_val[HW+1] = a_full;
    hs_val[HW+3] = a_avail;
    hs_val[1]    = b_flag;
  end

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign gen_dir[g] = (g >= HW) ? !cfg.cu_in : !cfg.cl_in;
    assign pc_oe[g]   = hs_out[g] || (!hs_in[g] && gen_dir[g]);
    assign pc_out[g]  = hs_out[g] ? hs_val[g] : c_lat[g];
    assign c_val[g]   = pc_oe[g] ? pc_out[g] : pc_in[g];
  end

  // R8: a handshake input pin is never driven by the block
  a_r8_no_drive_on_hs_in: assert final ((pc_oe & hs_in) == '0);
endmodule

// File: rtl/parallel_io_port.sv
module parallel_io_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       cs,
  input  logic [1:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] pa_in,
  output logic [7:0] pa_out,
  output logic       pa_oe,
  input  logic [7:0] pb_in,
  output logic [7:0] pb_out,
  output logic       pb_oe,
  input  logic [7:0] pc_in,
  output logic [7:0] pc_out,
  output logic [7:0] pc_oe
);
  import pp_pkg::*;

  cfg_t cfg_q;
  logic we_a, we_b, we_c, we_k, re_a, re_b;
  logic [DW-1:0] a_val, b_val, c_val, c_lat;
  logic [DW-1:0] a_out, a_inq, b_out, b_inq;
  logic a_full, a_avail, b_full, b_avail;
  logic a_bid, a_in_en, a_out_en, b_in_en, b_out_en;
  logic pa_oe_q;

  pp_busif #(.DW(DW)) u_bus (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .a_val(a_val), .b_val(b_val), .c_val(c_val), .k_val(cfg_q),
    .we_a(we_a), .we_b(we_b), .we_c(we_c), .we_k(we_k),
    .re_a(re_a), .re_b(re_b), .rdata(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
      c_lat <= '0;
    end else if (we_k) begin
      cfg_q <= cfg_t'(wdata);
      c_lat <= '0;
    end else if (we_c) begin
      c_lat <= wdata;
    end
  end

  assign a_bid    = cfg_q.a_mode[1];
  assign a_in_en  = a_bid || ((cfg_q.a_mode == AM_STROBE) && cfg_q.a_in);
  assign a_out_en = a_bid || ((cfg_q.a_mode == AM_STROBE) && !cfg_q.a_in);
  assign b_in_en  = cfg_q.b_stb && cfg_q.b_in;
  assign b_out_en = cfg_q.b_stb && !cfg_q.b_in;

  pp_hs #(.DW(DW)) u_hs_a (
    .clk(clk), .rst(rst), .clr(we_k), .in_en(a_in_en), .out_en(a_out_en),
    .cpu_wr(we_a), .cpu_rd(re_a), .wdata(wdata),
    .strobe_n(pc_in[HW]), .take_n(pc_in[HW+2]), .din(pa_in),
    .out_q(a_out), .in_q(a_inq), .full(a_full), .avail(a_avail)
  );

  pp_hs #(.DW(DW)) u_hs_b (
    .clk(clk), .rst(rst), .clr(we_k), .in_en(b_in_en), .out_en(b_out_en),
    .cpu_wr(we_b), .cpu_rd(re_b), .wdata(wdata),
    .strobe_n(pc_in[0]), .take_n(pc_in[0]), .din(pb_in),
    .out_q(b_out), .in_q(b_inq), .full(b_full), .avail(b_avail)
  );

  pp_portc #(.DW(DW)) u_pc (
    .cfg(cfg_q), .c_lat(c_lat), .pc_in(pc_in),
    .a_full(a_full), .a_avail(a_avail), .b_flag(cfg_q.b_in ? b_full : b_avail),
    .pc_out(pc_out), .pc_oe(pc_oe), .c_val(c_val)
  );

  always_comb begin
    if (a_in_en)          a_val = a_inq;
    else if (cfg_q.a_in)  a_val = pa_in;
    else                  a_val = a_out;
    if (b_in_en)          b_val = b_inq;
    else if (cfg_q.b_in)  b_val = pb_in;
    else                  b_val = b_out;
  end

  always_ff @(posedge clk) begin
    if (rst)        pa_oe_q <= 1'b0;
    else if (a_bid) pa_oe_q <= !pc_in[HW+2];
    else            pa_oe_q <= !cfg_q.a_in;
  end

  assign pa_out = a_out;
  assign pa_oe  = pa_oe_q;
  assign pb_out = b_out;
  assign pb_oe  = !cfg_q.b_in;

  // R2: a definition write leaves every output latch and flag at zero
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    we_k |=> (pa_out == '0 && pb_out == '0 && c_lat == '0 && !a_full && !a_avail && !b_full && !b_avail));
  // R3: a control write with the define bit clear leaves the configuration alone
  a_r3_ignore: assert property (@(posedge clk) disable iff (rst)
    (cs && wr && addr == ADR_K && !wdata[DW-1]) |=> $stable(cfg_q));
  // R9: in bidirectional mode the port A driver follows the acknowledge line
  a_r9_bidir_oe: assert property (@(posedge clk) disable iff (rst)
    (a_bid && pc_in[HW+2]) |=> !pa_oe);
endmodule

// File: tb/parallel_io_port_tb.sv
module parallel_io_port_tb;
  localparam time TCLK = 10ns;

  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pa_in = '0, pa_out, pb_in = '0, pb_out, pc_in = 8'hFF, pc_out, pc_oe;
  logic pa_oe, pb_oe;
  int errors = 0, checks = 0;
  logic [7:0] rv;

  always #(TCLK/2) clk = ~clk;

  parallel_io_port u_dut (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr), .rd(rd), .wr(wr), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; wr = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1; rd = 1; addr = a;
    @(negedge clk); cs = 0; rd = 0; d = rdata;
  endtask

  task automatic pulse_c(input int b);
    @(negedge clk); pc_in[b] = 1'b0;
    @(negedge clk); pc_in[b] = 1'b1;
  endtask

  task automatic t_reset;
    bus_rd(2'd3, rv);
    check("R1 ctrl", rv, 8'h9B);
    check("R1 oe", {6'b0, pa_oe, pb_oe}, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    @(negedge clk);
    check("R10 rdata hold", rdata, 8'h9B);
  endtask

  task automatic t_simple;
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd3, rv);
    check("R2 readback", rv, 8'h80);
    bus_wr(2'd0, 8'h5A);
    bus_wr(2'd1, 8'hC3);
    bus_wr(2'd2, 8'h7E);
    check("R4 pa_out", pa_out, 8'h5A);
    check("R4 pa_oe", {7'b0, pa_oe}, 8'h01);
    check("R4 pb_out", pb_out, 8'hC3);
    check("R5 pc_out", pc_out, 8'h7E);
    check("R5 pc_oe", pc_oe, 8'hFF);
    bus_wr(2'd3, 8'h80);
    check("R2 clear A", pa_out, 8'h00);
    check("R2 clear C", pc_out, 8'h00);
    bus_wr(2'd0, 8'h11);
    bus_wr(2'd3, 8'h12);
    check("R3 pa_out kept", pa_out, 8'h11);
    bus_rd(2'd3, rv);
    check("R3 ctrl kept", rv, 8'h80);
  endtask

  task automatic t_mixed;
    bus_wr(2'd3, 8'h98);
    pa_in = 8'hA5; pc_in = 8'hC5;
    bus_wr(2'd2, 8'h03);
    bus_rd(2'd0, rv);
    check("R4 read A pins", rv, 8'hA5);
    bus_rd(2'd2, rv);
    check("R5 read C mixed", rv, 8'hC3);
    check("R5 pc_oe", pc_oe, 8'h0F);
    check("R4 pb_oe", {7'b0, pb_oe}, 8'h01);
    check("R4 pa_oe", {7'b0, pa_oe}, 8'h00);
    pc_in = 8'hFF;
  endtask

  task automatic t_strobe_in_a;
    bus_wr(2'd3, 8'hB0);
    check("R8 pc_oe A in", pc_oe, 8'hEF);
    bus_wr(2'd2, 8'hC0);
    check("R8 C general bits", pc_out, 8'hC0);
    pa_in = 8'h3C;
    pulse_c(4);
    check("R6 full set", {7'b0, pc_out[5]}, 8'h01);
    pa_in = 8'h00;
    bus_rd(2'd0, rv);
    check("R6 captured", rv, 8'h3C);
    check("R6 full cleared", {7'b0, pc_out[5]}, 8'h00);
  endtask

  task automatic t_strobe_b;
    bus_wr(2'd3, 8'h9C);
    check("R8 pc_oe B out", pc_oe, 8'h0E);
    bus_wr(2'd1, 8'h77);
    check("R7 pb_out", pb_out, 8'h77);
    check("R7 ready set", {7'b0, pc_out[1]}, 8'h01);
    pulse_c(0);
    check("R7 ready cleared", {7'b0, pc_out[1]}, 8'h00);
    bus_wr(2'd3, 8'h9E);
    pb_in = 8'h42;
    pulse_c(0);
    check("R6 B full", {7'b0, pc_out[1]}, 8'h01);
    pb_in = 8'h00;
    bus_rd(2'd1, rv);
    check("R6 B captured", rv, 8'h42);
    check("R6 B full cleared", {7'b0, pc_out[1]}, 8'h00);
  endtask

  task automatic t_bidir;
    bus_wr(2'd3, 8'hC0);
    check("R8 pc_oe bidir", pc_oe, 8'hAF);
    bus_wr(2'd0, 8'h99);
    check("R9 ready", {7'b0, pc_out[7]}, 8'h01);
    check("R9 oe idle", {7'b0, pa_oe}, 8'h00);
    @(negedge clk); pc_in[6] = 1'b0;
    @(negedge clk);
    check("R9 oe on ack", {7'b0, pa_oe}, 8'h01);
    check("R9 drive data", pa_out, 8'h99);
    check("R9 ready cleared", {7'b0, pc_out[7]}, 8'h00);
    pc_in[6] = 1'b1;
    @(negedge clk);
    check("R9 oe released", {7'b0, pa_oe}, 8'h00);
    pa_in = 8'h66;
    pulse_c(4);
    check("R9 full", {7'b0, pc_out[5]}, 8'h01);
    bus_rd(2'd0, rv);
    check("R9 read in", rv, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_simple();
    t_mixed();
    t_strobe_in_a();
    t_strobe_b();
    t_bidir();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule